// File: doc/BRIEF.md
# Bit-Oriented Signaling Code Detector

This block monitors a serial data-link bit stream and recognises bit-oriented signaling codes. A code occupies sixteen bit times: an all-ones byte, then a code byte whose first-received and last-received bits are both zero. Bits arrive least significant bit first and are accepted only on cycles where the enable strobe is high, so the block can sit behind any framer that pulls data-link bits out of a line at an irregular rate.

The detector slides a sixteen-bit window along the stream one accepted bit at a time. The first time the pattern appears, it flags a start event and marks the message as bit-oriented. From then on it looks at the window only at sixteen-bit spacing. Each further copy of the same code increments a repeat count. When that count reaches the programmed threshold, the code byte is latched and an end-of-message event fires, together with a received length of one byte.

A different code, or a slot that does not match, ends the run. A build-time option can suppress reporting of a code equal to the one already held, so a far end that keeps sending the same request does not raise the host again.

Top module: `bos_code_detector`

## Requirements
- R1: While `rst_n` is low and after reset, `code_out` is 0, `msg_type` is 1, `rx_len` is 0, and `sot` and `eot` are 0.
- R2: The pattern is matched on the last sixteen accepted bits, with the first-received bit as bit 0 of each byte: the older byte must be 8'hFF, and the newer byte (the code) must have bit 0 and bit 7 equal to 0. The newer byte is the code that is reported in `code_out`.
- R3: A match found while no run is active starts a run with a count of 1. In the cycle after the accepted bit that completes that match, `sot` is high for one cycle and `msg_type` becomes 0.
- R4: Within a run, the window is examined again exactly sixteen accepted bits after the previous match. The same code there increments the count. When the count equals the threshold, `eot` pulses one cycle after the completing bit, `code_out` takes the code and `rx_len` becomes 1.
- R5: A threshold of 0 behaves like a threshold of 1, so the first match reports at once.
- R6: A different valid code at the sixteen-bit slot restarts the count at 1, and raises `sot` again.
- R7: No match at the sixteen-bit slot ends the run and clears the count. A later report needs a fresh run from a count of 1.
- R8: Once a run has reported, further repeats of the same code in that run raise no further `eot`.
- R9: With `DISCARD_DUP`=1, a code due for report that equals the code already held (with `rx_len` = 1) gives no `eot`, and `code_out` is unchanged. With `DISCARD_DUP`=0, that code is reported again.
- R10: Cycles with `rx_bit_en` low change no state and raise no `sot` or `eot`, whatever `rx_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial data-link bit |
| rx_bit_en | input | 1 | Accept `rx_bit` this cycle |
| rep_thresh | input | CNT_W | Repetitions required before a report (0 acts as 1) |
| code_out | output | BYTE_W | Last reported code byte |
| msg_type | output | 1 | 0 once a bit-oriented code has been seen |
| rx_len | output | LEN_W | Received message length in bytes (1 after a report) |
| sot | output | 1 | One-cycle start-of-code event |
| eot | output | 1 | One-cycle end-of-message event |

## Verification
The bench inserts long disabled gaps in the middle of a run. A design that shifts or counts on gated cycles would lose slot alignment and report late or not at all.

It switches codes back to back. A design that clears the run instead of restarting at 1 would need an extra repeat.

It breaks the ones prefix between copies. A design that keeps the old count would report one copy early.

It also keeps repeating a code after its report, sets the threshold to zero, and runs a suppressing and a non-suppressing instance on one stream. These cases expose a second `eot` in the same run, a missed immediate report, and a duplicate that leaks through (or is wrongly dropped).

// File: rtl/bos_det_pkg.sv
package bos_det_pkg;

   typedef enum logic {
      RUN_IDLE  = 1'b0,
      RUN_TRACK = 1'b1
   } run_state_e;

endpackage

// File: rtl/bos_det_shift.sv
module bos_det_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   input  logic              bit_en,
   output logic              hit,
   output logic [BYTE_W-1:0] code
);
   localparam int WIN_W = 2 * BYTE_W;

   logic [WIN_W-1:0] win_q;
   logic [WIN_W-1:0] win_d;

   assign win_d = {bit_in, win_q[WIN_W-1:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (bit_en) begin
         win_q <= win_d;
      end
   end

   assign code = win_d[WIN_W-1:BYTE_W];
   assign hit  = bit_en && (&win_d[BYTE_W-1:0])
                 && !win_d[BYTE_W] && !win_d[WIN_W-1];
endmodule

// File: rtl/bos_det_track.sv
module bos_det_track
   import bos_det_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              hit,
   input  logic [BYTE_W-1:0] code,
   input  logic [CNT_W-1:0]  thresh,
   output logic              start,
   output logic              report
);
   localparam int SLOT_LEN = 2 * BYTE_W;
   localparam int SLOT_W   = $clog2(SLOT_LEN);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_LEN - 1);
   localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
   localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

   run_state_e        st_q;
   logic [SLOT_W-1:0] pos_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] last_q;
   logic              done_q;

   logic [CNT_W-1:0]  thr_eff;
   logic [CNT_W-1:0]  cnt_inc;
   logic              slot_end;
   logic              again;
   logic              lose;

   always_comb begin
      thr_eff  = (thresh == '0) ? CNT_ONE : thresh;
      cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
      slot_end = bit_en && (st_q == RUN_TRACK) && (pos_q == SLOT_LAST);
      again    = slot_end && hit && (code == last_q);
      lose     = slot_end && !hit;
      start    = hit && ((st_q == RUN_IDLE) || (slot_end && (code != last_q)));
      report   = (start && (thr_eff == CNT_ONE))
                 || (again && !done_q && (cnt_inc == thr_eff));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= RUN_IDLE;
         pos_q  <= '0;
         cnt_q  <= '0;
         last_q <= '0;
         done_q <= 1'b0;
      end else if (bit_en) begin
         if (start) begin
            st_q   <= RUN_TRACK;
            pos_q  <= '0;
            cnt_q  <= CNT_ONE;
            last_q <= code;
            done_q <= report;
         end else if (again) begin
            pos_q  <= '0;
            cnt_q  <= cnt_inc;
            done_q <= done_q | report;
         end else if (lose) begin
            st_q   <= RUN_IDLE;
            pos_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
         end else if (st_q == RUN_TRACK) begin
            pos_q  <= pos_q + SLOT_W'(1);
         end
      end
   end
endmodule

// File: rtl/bos_det_report.sv
module bos_det_report #(
   parameter int BYTE_W      = 8,
   parameter int LEN_W       = 8,
   parameter bit DISCARD_DUP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              report,
   input  logic [BYTE_W-1:0] code,
   output logic [BYTE_W-1:0] code_out,
   output logic              msg_type,
   output logic [LEN_W-1:0]  rx_len,
   output logic              sot,
   output logic              eot
);
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   logic allow;

   generate
      if (DISCARD_DUP) begin : g_discard
         assign allow = !((rx_len == LEN_ONE) && (code == code_out));
      end else begin : g_keep
         assign allow = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_out <= '0;
         msg_type <= 1'b1;
         rx_len   <= '0;
         sot      <= 1'b0;
         eot      <= 1'b0;
      end else begin
         sot <= start;
         eot <= report && allow;
         if (start) begin
            msg_type <= 1'b0;
         end
         if (report && allow) begin
            code_out <= code;
            rx_len   <= LEN_ONE;
         end
      end
   end
endmodule

// File: rtl/bos_code_detector.sv
module bos_code_detector #(
   parameter int BYTE_W      = 8,
   parameter int CNT_W       = 8,
   parameter int LEN_W       = 8,
   parameter bit DISCARD_DUP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_bit,
   input  logic              rx_bit_en,
   input  logic [CNT_W-1:0]  rep_thresh,
   output logic [BYTE_W-1:0] code_out,
   output logic              msg_type,
   output logic [LEN_W-1:0]  rx_len,
   output logic              sot,
   output logic              eot
);
   generate
      if (BYTE_W < 3) begin : g_bad_byte
         $error("BYTE_W must be at least 3");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
   endgenerate

   logic              hit;
   logic [BYTE_W-1:0] win_code;
   logic              start;
   logic              report;

   bos_det_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_in (rx_bit),
      .bit_en (rx_bit_en),
      .hit    (hit),
      .code   (win_code)
   );

   bos_det_track #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (rx_bit_en),
      .hit    (hit),
      .code   (win_code),
      .thresh (rep_thresh),
      .start  (start),
      .report (report)
   );

   bos_det_report #(.BYTE_W(BYTE_W), .LEN_W(LEN_W), .DISCARD_DUP(DISCARD_DUP)) u_report (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .report   (report),
      .code     (win_code),
      .code_out (code_out),
      .msg_type (msg_type),
      .rx_len   (rx_len),
      .sot      (sot),
      .eot      (eot)
   );
endmodule

// File: rtl/bos_code_detector_chk.sv
module bos_code_detector_chk #(
   parameter int BYTE_W = 8,
   parameter int LEN_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_bit_en,
   input logic [BYTE_W-1:0] code_out,
   input logic              msg_type,
   input logic [LEN_W-1:0]  rx_len,
   input logic              sot,
   input logic              eot
);
   assert_sot_marks_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sot |-> !msg_type);

   assert_eot_one_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      eot |-> (!msg_type && (rx_len == LEN_W'(1))));

   assert_code_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eot |-> (!code_out[0] && !code_out[BYTE_W-1]));

   assert_gated_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_bit_en) |-> (!sot && !eot && $stable(code_out)));

   assert_code_only_on_eot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !eot |-> $stable(code_out));
endmodule

bind bos_code_detector bos_code_detector_chk #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_bit_en (rx_bit_en),
   .code_out  (code_out),
   .msg_type  (msg_type),
   .rx_len    (rx_len),
   .sot       (sot),
   .eot       (eot)
);

// File: tb/bos_code_detector_bench.sv
module bos_code_detector_bench;
   localparam int BW = 8;
   localparam int CW = 8;
   localparam int LW = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          rx_bit;
   logic          rx_bit_en;
   logic [CW-1:0] thr;

   logic [BW-1:0] code_a, code_b;
   logic          type_a, type_b;
   logic [LW-1:0] len_a, len_b;
   logic          sot_a, sot_b, eot_a, eot_b;

   bos_code_detector #(.BYTE_W(BW), .CNT_W(CW), .LEN_W(LW), .DISCARD_DUP(1'b0)) u_bos_code_detector (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en), .rep_thresh(thr),
      .code_out(code_a), .msg_type(type_a), .rx_len(len_a), .sot(sot_a), .eot(eot_a));

   bos_code_detector #(.BYTE_W(BW), .CNT_W(CW), .LEN_W(LW), .DISCARD_DUP(1'b1)) u_bos_code_detector_dd (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en), .rep_thresh(thr),
      .code_out(code_b), .msg_type(type_b), .rx_len(len_b), .sot(sot_b), .eot(eot_b));

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   // reference state derived from the requirements
   logic [15:0] m_win = '0;
   bit          m_trk = 0;
   int          m_pos = 0;
   int          m_rep = 0;
   logic [7:0]  m_last = '0;
   bit          m_done = 0;
   logic [7:0]  m_code = '0;
   bit          m_type = 1;
   int          m_len = 0;
   logic [7:0]  m_code_d = '0;
   int          m_len_d = 0;
   bit          e_sot, e_eot, e_eot_d;
   int          n_sot_a = 0, n_eot_a = 0, n_eot_b = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_report(input logic [7:0] c);
      m_done = 1;
      e_eot  = 1;
      m_code = c;
      m_len  = 1;
      if (!(m_len_d == 1 && m_code_d == c)) begin
         e_eot_d  = 1;
         m_code_d = c;
         m_len_d  = 1;
      end
   endtask

   task automatic do_start(input logic [7:0] c, input int te);
      m_trk  = 1;
      m_pos  = 0;
      m_rep  = 1;
      m_last = c;
      m_done = 0;
      e_sot  = 1;
      m_type = 0;
      if (te == 1) do_report(c);
   endtask

   task automatic model(input bit b, input bit en);
      logic [7:0] c;
      bit hit;
      int te;
      e_sot = 0; e_eot = 0; e_eot_d = 0;
      if (en) begin
         m_win = {b, m_win[15:1]};
         hit = (m_win[7:0] == 8'hFF) && !m_win[8] && !m_win[15];
         c   = m_win[15:8];
         te  = (thr == 0) ? 1 : int'(thr);
         if (m_trk) begin
            m_pos++;
            if (m_pos == 16) begin
               m_pos = 0;
               if (hit && c == m_last) begin
                  if (m_rep < 255) m_rep++;
                  if (m_rep == te && !m_done) do_report(c);
               end else if (hit) begin
                  do_start(c, te);
               end else begin
                  m_trk = 0;
                  m_rep = 0;
               end
            end
         end else if (hit) begin
            do_start(c, te);
         end
      end
   endtask

   task automatic step(input bit b, input bit en);
      @(negedge clk);
      rx_bit    = b;
      rx_bit_en = en;
      @(posedge clk);
      #2;
      model(b, en);
      chk("R3 sot", sot_a, e_sot);
      chk("R4 eot", eot_a, e_eot);
      chk("R2 code_out", code_a, m_code);
      chk("R3 msg_type", type_a, m_type);
      chk("R4 rx_len", len_a, m_len);
      chk("R6 sot dd", sot_b, e_sot);
      chk("R9 eot dd", eot_b, e_eot_d);
      chk("R9 code_out dd", code_b, m_code_d);
      if (sot_a) n_sot_a++;
      if (eot_a) n_eot_a++;
      if (eot_b) n_eot_b++;
   endtask

   task automatic send_byte(input logic [7:0] v, input int gap);
      for (int i = 0; i < 8; i++) begin
         step(v[i], 1'b1);
         for (int g = 0; g < gap; g++) step(1'($urandom), 1'b0);
      end
   endtask

   task automatic send_code(input logic [7:0] v);
      send_byte(8'hFF, 0);
      send_byte(v, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int base_e, base_s, base_b;
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; rx_bit = 1'b0; rx_bit_en = 1'b0; thr = 8'd3;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset code", code_a, 0);
      chk("R1 reset type", type_a, 1);
      chk("R1 reset len", len_a, 0);
      chk("R1 reset events", {sot_a, eot_a}, 0);
      @(negedge clk) rst_n = 1'b1;

      // R4 / R10: threshold 3, with a long gated gap mid-run
      base_e = n_eot_a;
      send_code(8'h12);
      for (int g = 0; g < 20; g++) step(1'($urandom), 1'b0);
      chk("R10 no event in gap", n_eot_a - base_e, 0);
      send_code(8'h12);
      chk("R4 no early eot", n_eot_a - base_e, 0);
      send_code(8'h12);
      chk("R4 eot count", n_eot_a - base_e, 1);
      chk("R4 code stored", code_a, 8'h12);
      chk("R4 len one", len_a, 1);

      // R8: more repeats after the report
      send_code(8'h12);
      send_code(8'h12);
      chk("R8 no second eot", n_eot_a - base_e, 1);

      // R6: different code restarts at 1
      base_s = n_sot_a;
      base_e = n_eot_a;
      send_code(8'h24);
      send_code(8'h24);
      chk("R6 sot again", n_sot_a - base_s, 1);
      chk("R6 not yet", n_eot_a - base_e, 0);
      send_code(8'h24);
      chk("R6 eot after third", n_eot_a - base_e, 1);
      chk("R6 code", code_a, 8'h24);

      // R7: broken prefix clears the count
      send_byte(8'h00, 0); send_byte(8'h00, 0);
      thr = 8'd2;
      base_e = n_eot_a;
      send_code(8'h3C);
      send_byte(8'h00, 0); send_byte(8'h00, 0);
      send_code(8'h3C);
      chk("R7 restart no eot", n_eot_a - base_e, 0);
      send_code(8'h3C);
      chk("R7 eot after fresh pair", n_eot_a - base_e, 1);

      // R9: duplicate with threshold 1
      send_byte(8'h00, 0); send_byte(8'h00, 0);
      thr = 8'd1;
      base_e = n_eot_a;
      base_b = n_eot_b;
      send_code(8'h3C);
      chk("R9 keep reports dup", n_eot_a - base_e, 1);
      chk("R9 discard drops dup", n_eot_b - base_b, 0);
      chk("R9 discard code held", code_b, 8'h3C);
      send_code(8'h42);
      chk("R9 discard new code", n_eot_b - base_b, 1);
      chk("R9 discard code new", code_b, 8'h42);

      // R5: threshold zero
      send_byte(8'h00, 0); send_byte(8'h00, 0);
      thr = 8'd0;
      base_e = n_eot_a;
      send_code(8'h66);
      chk("R5 zero acts as one", n_eot_a - base_e, 1);
      chk("R5 code", code_a, 8'h66);

      // random phase
      for (int n = 0; n < 2500; n++) begin
         int r;
         int gap;
         logic [7:0] v;
         if (n % 200 == 0) thr = CW'($urandom % 5);
         r = int'($urandom % 8);
         if (r < 3) v = 8'hFF;
         else if (r < 6) v = {1'b0, 6'(($urandom % 3) * 9 + 3), 1'b0};
         else v = 8'($urandom);
         gap = (($urandom % 4) == 0) ? int'($urandom % 3) : 0;
         send_byte(v, gap);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule